// File: doc/BRIEF.md
# Log-Block Merge Sequencer

This block decides how a hybrid address-translation layer folds one page-mapped log block back into the block-mapped data table, and then sends out the commands that carry the fold out. When `start` is pulsed it takes a snapshot of the logical page number and valid flag of every page slot in the log block. One cycle later it classifies the block. The block is a switch merge when one whole chunk sits in slot order. It is a partial merge when a leading run of one chunk sits in slot order and every later slot is empty. Anything else is a full merge.

Each merge type leads to its own ordered stream of commands on a valid/ready channel: page reads, page writes, data-table updates, log-table invalidations and erases. Each command carries a chunk number, an in-chunk offset and a log slot. A downstream engine resolves the physical blocks, moves the page data and allocates fresh blocks. The sequencer only orders the work. It reports the end of the work with a one-cycle done pulse that carries the merge type.

Top module: `mrg_merge_seq`

## Requirements
- R1: A log block whose slot i (for every i) is valid and holds page offset i of one chunk C is a switch merge. The stream is: INV for slots 0..3 in ascending order, then MAP_LOG(C), then ERASE_OLD(C). No read or write is issued. The done type is 0.
- R2: A log block whose slots 0..k-1 (1 <= k <= 3) hold offsets 0..k-1 of chunk C in order, and whose later slots are all invalid, is a partial merge. For each offset o from k to 3 the stream issues RD_DATA(C,o) and then WR_LOG(C,o,slot o). It then issues INV for slots 0..k-1, MAP_LOG(C) and ERASE_OLD(C). The done type is 1.
- R3: Every other non-empty log block is a full merge, and its chunks are handled in ascending chunk order. For each chunk C and each offset o = 0..3, the stream issues a read followed by WR_NEW(C,o). The read is RD_LOG from the highest-numbered valid slot that holds (C,o), or RD_DATA(C,o) if no valid slot holds that page. After the four pairs come MAP_NEW(C) and ERASE_OLD(C). After the last chunk come INV for every valid slot in ascending order, and then ERASE_LOG. The done type is 2.
- R4: A log block with no valid slot is treated as a full merge. Its stream is only ERASE_LOG, and the done type is 2.
- R5: `cmd_valid` stays low in the cycle after `start` is taken. That cycle is spent on classification.
- R6: While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady and `cmd_valid` stays high. A command counts as issued only on a cycle where both `cmd_valid` and `cmd_ready` are high.
- R7: `busy` rises on the edge that takes `start` and falls on the edge that accepts the final erase. `done` pulses for exactly one cycle, right after that edge, with `done_type`. A `start` that arrives while `busy` is high has no effect.
- R8: After reset, `busy`, `cmd_valid` and `done` are low.
- R9: The `cmd_op` codes are: RD_LOG=0, RD_DATA=1, WR_LOG=2, WR_NEW=3, MAP_LOG=4, MAP_NEW=5, INV=6, ERASE_OLD=7, ERASE_LOG=8. INV carries only the slot. MAP and ERASE_OLD carry only the chunk. ERASE_LOG carries nothing. RD_DATA and WR_NEW carry the chunk and offset. Every field a command does not carry is zero. The logical page number is {chunk, offset}, with the offset in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a merge; taken only while idle |
| log_lpn | input | PAGES*LPN_W | Logical page number of each log slot, with slot 0 in the low bits |
| log_vld | input | PAGES | Valid flag of each log slot |
| busy | output | 1 | A merge is in progress |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The consumer takes the offered command |
| cmd_op | output | 4 | Command code |
| cmd_chunk | output | LPN_W-log2(PAGES) | Chunk number |
| cmd_ofs | output | log2(PAGES) | Offset within the chunk |
| cmd_slot | output | log2(PAGES) | Log block slot |
| done | output | 1 | One-cycle end-of-merge pulse |
| done_type | output | 2 | Merge type: 0 switch, 1 partial, 2 full |

## Verification
The inputs are taken at the edge where `start` is high. `busy` is therefore visible in the next cycle, and the first command is offered one cycle after that. From then on, each command changes on the edge after the edge that accepted it. `done` and `done_type` appear in the cycle right after the final erase is accepted. The bench drives `cmd_ready` and samples every output on the falling edge. It logs a command only on a falling edge where valid and ready are both high, which is the command the next rising edge accepts. It checks `done` before it drives anything further in that cycle.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

   typedef enum logic [3:0] {
      OP_RD_LOG    = 4'd0,
      OP_RD_DATA   = 4'd1,
      OP_WR_LOG    = 4'd2,
      OP_WR_NEW    = 4'd3,
      OP_MAP_LOG   = 4'd4,
      OP_MAP_NEW   = 4'd5,
      OP_INV       = 4'd6,
      OP_ERASE_OLD = 4'd7,
      OP_ERASE_LOG = 4'd8
   } mrg_op_e;

   typedef enum logic [1:0] {
      MT_SWITCH  = 2'd0,
      MT_PARTIAL = 2'd1,
      MT_FULL    = 2'd2
   } mrg_type_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CLASS, S_PRD, S_PWR, S_INV, S_MAP, S_ERO,
      S_FRD, S_FWR, S_FMAP, S_FERO, S_ERL
   } mrg_state_e;

endpackage

// File: rtl/mrg_classify.sv
module mrg_classify
   import mrg_pkg::*;
#(
   parameter int PAGES = 4,
   parameter int LPN_W = 12,
   localparam int OFS_W = $clog2(PAGES),
   localparam int CHUNK_W = LPN_W - OFS_W
) (
   input  logic [PAGES*LPN_W-1:0] lpn,
   input  logic [PAGES-1:0]       vld,
   output mrg_type_e              kind,
   output logic [CHUNK_W-1:0]     chunk0,
   output logic [OFS_W:0]         lead
);

   logic [PAGES-1:0] inorder;
   logic             run;
   logic             tail_clear;

   assign chunk0 = lpn[OFS_W +: CHUNK_W];

   // slot i sits in place when it holds offset i of slot 0's chunk
   for (genvar i = 0; i < PAGES; i++) begin : g_place
      assign inorder[i] = vld[i] && (lpn[i*LPN_W +: LPN_W] == {chunk0, OFS_W'(i)});
   end

   always_comb begin
      lead       = '0;
      run        = 1'b1;
      tail_clear = 1'b1;
      for (int i = 0; i < PAGES; i++) begin
         if (run && inorder[i]) begin
            lead = lead + 1'b1;
         end else begin
            run = 1'b0;
            if (vld[i]) tail_clear = 1'b0;
         end
      end
   end

   always_comb begin
      if (lead == (OFS_W+1)'(PAGES))         kind = MT_SWITCH;
      else if (lead != '0 && tail_clear)     kind = MT_PARTIAL;
      else                                   kind = MT_FULL;
   end

endmodule

// File: rtl/mrg_chunk_min.sv
module mrg_chunk_min #(
   parameter int PAGES   = 4,
   parameter int CHUNK_W = 10
) (
   input  logic [PAGES*CHUNK_W-1:0] chunks,
   input  logic [PAGES-1:0]         mask,
   output logic                     any,
   output logic [CHUNK_W-1:0]       lo
);

   always_comb begin
      any = 1'b0;
      lo  = '0;
      for (int i = 0; i < PAGES; i++) begin
         if (mask[i] && (!any || chunks[i*CHUNK_W +: CHUNK_W] < lo)) begin
            lo  = chunks[i*CHUNK_W +: CHUNK_W];
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mrg_slot_find.sv
module mrg_slot_find #(
   parameter int PAGES = 4,
   parameter int LPN_W = 12,
   localparam int OFS_W = $clog2(PAGES)
) (
   input  logic [PAGES*LPN_W-1:0] lpn,
   input  logic [PAGES-1:0]       vld,
   input  logic [LPN_W-1:0]       key,
   output logic                   hit,
   output logic [OFS_W-1:0]       slot
);

   // ascending scan: the highest matching slot, the newest copy, wins
   always_comb begin
      hit  = 1'b0;
      slot = '0;
      for (int i = 0; i < PAGES; i++) begin
         if (vld[i] && lpn[i*LPN_W +: LPN_W] == key) begin
            hit  = 1'b1;
            slot = OFS_W'(i);
         end
      end
   end

endmodule

// File: rtl/mrg_merge_seq.sv
module mrg_merge_seq
   import mrg_pkg::*;
#(
   parameter int PAGES = 4,
   parameter int LPN_W = 12,
   localparam int OFS_W = $clog2(PAGES),
   localparam int CHUNK_W = LPN_W - OFS_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [PAGES*LPN_W-1:0] log_lpn,
   input  logic [PAGES-1:0]       log_vld,
   output logic                   busy,
   output logic                   cmd_valid,
   input  logic                   cmd_ready,
   output logic [3:0]             cmd_op,
   output logic [CHUNK_W-1:0]     cmd_chunk,
   output logic [OFS_W-1:0]       cmd_ofs,
   output logic [OFS_W-1:0]       cmd_slot,
   output logic                   done,
   output logic [1:0]             done_type
);

   localparam logic [OFS_W-1:0] LAST = OFS_W'(PAGES - 1);

   if (PAGES < 2 || (1 << OFS_W) != PAGES) begin : g_bad_pages
      $error("PAGES must be a power of two of at least 2");
   end
   if (CHUNK_W < 1) begin : g_bad_lpn
      $error("LPN_W must exceed the offset width");
   end

   mrg_state_e               state;
   mrg_type_e                typ;
   logic [PAGES*LPN_W-1:0]   snap_lpn;
   logic [PAGES-1:0]         snap_vld;
   logic [CHUNK_W-1:0]       chk;
   logic [OFS_W-1:0]         ofs;
   logic [OFS_W-1:0]         idx;
   logic [PAGES-1:0]         done_mask;

   mrg_type_e                cls_type;
   logic [CHUNK_W-1:0]       cls_chunk;
   logic [OFS_W:0]           cls_lead;

   logic [PAGES*CHUNK_W-1:0] sn_chunks;
   logic [PAGES-1:0]         eq_cur;
   logic                     pick_any;
   logic [CHUNK_W-1:0]       cur_chunk;
   logic                     f_hit;
   logic [OFS_W-1:0]         f_slot;
   logic                     acc;

   for (genvar i = 0; i < PAGES; i++) begin : g_chunks
      assign sn_chunks[i*CHUNK_W +: CHUNK_W] = snap_lpn[i*LPN_W + OFS_W +: CHUNK_W];
      assign eq_cur[i] = (snap_lpn[i*LPN_W + OFS_W +: CHUNK_W] == cur_chunk);
   end

   mrg_classify #(.PAGES(PAGES), .LPN_W(LPN_W)) i_classify (
      .lpn    (snap_lpn),
      .vld    (snap_vld),
      .kind   (cls_type),
      .chunk0 (cls_chunk),
      .lead   (cls_lead)
   );

   mrg_chunk_min #(.PAGES(PAGES), .CHUNK_W(CHUNK_W)) i_chunk_min (
      .chunks (sn_chunks),
      .mask   (snap_vld & ~done_mask),
      .any    (pick_any),
      .lo     (cur_chunk)
   );

   mrg_slot_find #(.PAGES(PAGES), .LPN_W(LPN_W)) i_slot_find (
      .lpn  (snap_lpn),
      .vld  (snap_vld),
      .key  ({cur_chunk, ofs}),
      .hit  (f_hit),
      .slot (f_slot)
   );

   assign busy = (state != S_IDLE);
   assign acc  = cmd_valid && cmd_ready;

   always_comb begin
      cmd_valid = 1'b0;
      cmd_op    = OP_RD_LOG;
      cmd_chunk = '0;
      cmd_ofs   = '0;
      cmd_slot  = '0;
      unique case (state)
         S_PRD: begin
            cmd_valid = 1'b1; cmd_op = OP_RD_DATA; cmd_chunk = chk; cmd_ofs = ofs;
         end
         S_PWR: begin
            cmd_valid = 1'b1; cmd_op = OP_WR_LOG; cmd_chunk = chk; cmd_ofs = ofs;
            cmd_slot  = ofs;
         end
         S_INV: begin
            cmd_valid = snap_vld[idx]; cmd_op = OP_INV; cmd_slot = idx;
         end
         S_MAP: begin
            cmd_valid = 1'b1; cmd_op = OP_MAP_LOG; cmd_chunk = chk;
         end
         S_ERO: begin
            cmd_valid = 1'b1; cmd_op = OP_ERASE_OLD; cmd_chunk = chk;
         end
         S_FRD: begin
            cmd_valid = 1'b1; cmd_chunk = cur_chunk; cmd_ofs = ofs;
            if (f_hit) begin
               cmd_op   = OP_RD_LOG;
               cmd_slot = f_slot;
            end else begin
               cmd_op   = OP_RD_DATA;
            end
         end
         S_FWR: begin
            cmd_valid = 1'b1; cmd_op = OP_WR_NEW; cmd_chunk = cur_chunk; cmd_ofs = ofs;
         end
         S_FMAP: begin
            cmd_valid = 1'b1; cmd_op = OP_MAP_NEW; cmd_chunk = cur_chunk;
         end
         S_FERO: begin
            cmd_valid = 1'b1; cmd_op = OP_ERASE_OLD; cmd_chunk = cur_chunk;
         end
         S_ERL: begin
            cmd_valid = 1'b1; cmd_op = OP_ERASE_LOG;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         typ       <= MT_SWITCH;
         snap_lpn  <= '0;
         snap_vld  <= '0;
         chk       <= '0;
         ofs       <= '0;
         idx       <= '0;
         done_mask <= '0;
         done      <= 1'b0;
         done_type <= 2'd0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               snap_lpn  <= log_lpn;
               snap_vld  <= log_vld;
               done_mask <= '0;
               state     <= S_CLASS;
            end
            S_CLASS: begin
               typ <= cls_type;
               chk <= cls_chunk;
               idx <= '0;
               ofs <= '0;
               unique case (cls_type)
                  MT_SWITCH:  state <= S_INV;
                  MT_PARTIAL: begin
                     ofs   <= cls_lead[OFS_W-1:0];
                     state <= S_PRD;
                  end
                  default:    state <= pick_any ? S_FRD : S_INV;
               endcase
            end
            S_PRD: if (acc) state <= S_PWR;
            S_PWR: if (acc) begin
               if (ofs == LAST) begin
                  state <= S_INV;
                  idx   <= '0;
               end else begin
                  ofs   <= ofs + 1'b1;
                  state <= S_PRD;
               end
            end
            S_INV: if (!cmd_valid || cmd_ready) begin
               if (idx == LAST) state <= (typ == MT_FULL) ? S_ERL : S_MAP;
               else             idx   <= idx + 1'b1;
            end
            S_MAP: if (acc) state <= S_ERO;
            S_ERO, S_ERL: if (acc) begin
               state     <= S_IDLE;
               done      <= 1'b1;
               done_type <= typ;
            end
            S_FRD: if (acc) state <= S_FWR;
            S_FWR: if (acc) begin
               if (ofs == LAST) begin
                  ofs   <= '0;
                  state <= S_FMAP;
               end else begin
                  ofs   <= ofs + 1'b1;
                  state <= S_FRD;
               end
            end
            S_FMAP: if (acc) state <= S_FERO;
            S_FERO: if (acc) begin
               done_mask <= done_mask | (snap_vld & eq_cur);
               if (|(snap_vld & ~done_mask & ~eq_cur)) begin
                  state <= S_FRD;
               end else begin
                  state <= S_INV;
                  idx   <= '0;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mrg_seq_chk.sv
module mrg_seq_chk
   import mrg_pkg::*;
#(
   parameter int PAGES = 4,
   parameter int LPN_W = 12,
   localparam int OFS_W = $clog2(PAGES),
   localparam int CHUNK_W = LPN_W - OFS_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic [3:0]         cmd_op,
   input logic [CHUNK_W-1:0] cmd_chunk,
   input logic [OFS_W-1:0]   cmd_ofs,
   input logic [OFS_W-1:0]   cmd_slot,
   input logic               done,
   input logic [1:0]         done_type
);

   logic [7:0] n_copy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 n_copy <= '0;
      else if (start && !busy)    n_copy <= '0;
      else if (cmd_valid && cmd_ready && cmd_op <= 4'd3) n_copy <= n_copy + 1'b1;
   end

   p_no_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_type == 2'd0 |-> n_copy == '0);

   p_partial_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_type == 2'd1 |-> n_copy != '0);

   p_classify_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !cmd_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_chunk)
                                  && $stable(cmd_ofs) && $stable(cmd_slot));

   p_end_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done && $past(cmd_valid && cmd_ready)
                      && ($past(cmd_op) == 4'd7 || $past(cmd_op) == 4'd8));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_type != 2'd3 && !busy);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_valid);

endmodule

bind mrg_merge_seq mrg_seq_chk #(.PAGES(PAGES), .LPN_W(LPN_W)) i_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_chunk (cmd_chunk),
   .cmd_ofs   (cmd_ofs),
   .cmd_slot  (cmd_slot),
   .done      (done),
   .done_type (done_type)
);

// File: tb/test_mrg_merge_seq.sv
module test_mrg_merge_seq;

   localparam int PG = 4;
   localparam int LW = 12;
   localparam int CW = 10;

   localparam logic [3:0] RDL = 4'd0, RDD = 4'd1, WRL = 4'd2, WRN = 4'd3,
                          MPL = 4'd4, MPN = 4'd5, INV = 4'd6, ERO = 4'd7, ERL = 4'd8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            start;
   logic [PG*LW-1:0] log_lpn;
   logic [PG-1:0]   log_vld;
   logic            busy, cmd_valid, cmd_ready, done;
   logic [3:0]      cmd_op;
   logic [CW-1:0]   cmd_chunk;
   logic [1:0]      cmd_ofs, cmd_slot, done_type;

   int checks = 0;
   int fails  = 0;

   logic [17:0]     exp_q [64];
   int              exp_n;
   int              exp_type;
   string           exp_tag;
   logic [PG*LW-1:0] cur_lpn;
   logic [PG-1:0]   cur_vld;

   always #5 clk = ~clk;

   mrg_merge_seq #(.PAGES(PG), .LPN_W(LW)) i_mrg_merge_seq (
      .clk, .rst_n, .start, .log_lpn, .log_vld, .busy, .cmd_valid, .cmd_ready,
      .cmd_op, .cmd_chunk, .cmd_ofs, .cmd_slot, .done, .done_type
   );

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: run hung, got %0d exp 0 pending cycles", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   function automatic logic [LW-1:0] lp(input int i);
      return cur_lpn[i*LW +: LW];
   endfunction

   task automatic push(input logic [3:0] op, input int c, input int o, input int s);
      exp_q[exp_n] = {op, CW'(c), 2'(o), 2'(s)};
      exp_n++;
   endtask

   task automatic build_exp();
      int c0, k;
      bit run, tail;
      exp_n = 0;
      c0 = int'(lp(0) >> 2);
      k = 0; run = 1; tail = 1;
      for (int i = 0; i < PG; i++) begin
         if (run && cur_vld[i] && lp(i) == LW'(c0 * 4 + i)) k++;
         else begin run = 0; if (cur_vld[i]) tail = 0; end
      end
      if (k == PG) begin
         exp_type = 0; exp_tag = "R1";
         for (int i = 0; i < PG; i++) push(INV, 0, 0, i);
         push(MPL, c0, 0, 0); push(ERO, c0, 0, 0);
      end else if (k >= 1 && tail) begin
         exp_type = 1; exp_tag = "R2";
         for (int o = k; o < PG; o++) begin push(RDD, c0, o, 0); push(WRL, c0, o, o); end
         for (int i = 0; i < k; i++) push(INV, 0, 0, i);
         push(MPL, c0, 0, 0); push(ERO, c0, 0, 0);
      end else begin
         int prev;
         exp_type = 2; exp_tag = (cur_vld == 0) ? "R4" : "R3";
         prev = -1;
         forever begin
            int best;
            best = -1;
            for (int s = 0; s < PG; s++)
               if (cur_vld[s] && int'(lp(s) >> 2) > prev && (best < 0 || int'(lp(s) >> 2) < best))
                  best = int'(lp(s) >> 2);
            if (best < 0) break;
            for (int o = 0; o < PG; o++) begin
               int hit;
               hit = -1;
               for (int s = 0; s < PG; s++)
                  if (cur_vld[s] && lp(s) == LW'(best * 4 + o)) hit = s;
               if (hit >= 0) push(RDL, best, o, hit);
               else          push(RDD, best, o, 0);
               push(WRN, best, o, 0);
            end
            push(MPN, best, 0, 0); push(ERO, best, 0, 0);
            prev = best;
         end
         for (int i = 0; i < PG; i++) if (cur_vld[i]) push(INV, 0, 0, i);
         push(ERL, 0, 0, 0);
      end
   endtask

   task automatic run_case(input logic [PG*LW-1:0] l, input logic [PG-1:0] v, input bit inject);
      int got, bad, stab_bad, n;
      bit stall, seen;
      logic [17:0] stall_val, word, bad_act, bad_exp;
      cur_lpn = l; cur_vld = v;
      build_exp();
      log_lpn = l; log_vld = v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R7", "busy after start", 32'(busy), 1);
      chk(cmd_valid === 1'b0, "R5", "no command during classify", 32'(cmd_valid), 0);
      got = 0; bad = 0; stab_bad = 0; n = 0; stall = 0; seen = 0;
      bad_act = '0; bad_exp = '0;
      while (!seen && n < 2000) begin
         n++;
         word = {cmd_op, cmd_chunk, cmd_ofs, cmd_slot};
         if (done) begin
            seen = 1;
            chk(32'(done_type) == 32'(exp_type), exp_tag, "done type", 32'(done_type), 32'(exp_type));
            chk(busy == 1'b0, "R7", "busy low at done", 32'(busy), 0);
         end else begin
            if (stall && (!cmd_valid || word != stall_val)) stab_bad++;
            if (inject && n == 3) begin
               start = 1'b1; log_lpn = {$urandom, $urandom}; log_vld = 4'($urandom);
            end else start = 1'b0;
            cmd_ready = ($urandom % 4) != 0;
            if (cmd_valid) begin
               if (cmd_ready) begin
                  if (got >= exp_n || word != exp_q[got]) begin
                     if (bad == 0) begin
                        bad_act = word;
                        bad_exp = (got < exp_n) ? exp_q[got] : '1;
                     end
                     bad++;
                  end
                  got++;
                  stall = 0;
               end else begin
                  stall = 1; stall_val = word;
               end
            end else stall = 0;
            @(negedge clk);
         end
      end
      cmd_ready = 1'b0; start = 1'b0;
      chk(seen, "R7", "done reached", 32'(seen), 1);
      chk(got == exp_n, exp_tag, "command count", 32'(got), 32'(exp_n));
      chk(bad == 0, {exp_tag, "/R9"}, "command stream", 32'(bad_act), 32'(bad_exp));
      chk(stab_bad == 0, "R6", "held command", 32'(stab_bad), 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R7", "single done pulse, stray start ignored",
          {30'd0, done, busy}, 0);
   endtask

   function automatic logic [LW-1:0] pg(input int c, input int o);
      return LW'(c * 4 + o);
   endfunction

   initial begin
      void'($urandom(32'd7177));
      rst_n = 1'b0; start = 1'b0; cmd_ready = 1'b0; log_lpn = '0; log_vld = '0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && cmd_valid == 1'b0 && done == 1'b0, "R8", "reset state",
          {29'd0, busy, cmd_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 switch merge, chunk 37
      run_case({pg(37,3), pg(37,2), pg(37,1), pg(37,0)}, 4'b1111, 1'b1);
      // R2 partial merges with k=2 and k=1
      run_case({pg(9,0), pg(9,0), pg(81,1), pg(81,0)}, 4'b0011, 1'b1);
      run_case({pg(1,3), pg(1,2), pg(1,1), pg(255,0)}, 4'b0001, 1'b0);
      // R3 chunks out of order, chunk 5 before 2 in slots
      run_case({pg(2,3), pg(5,1), pg(2,0), pg(5,2)}, 4'b1111, 1'b1);
      // R3 newest copy wins: slots 0 and 3 hold the same page
      run_case({pg(12,1), pg(12,0), pg(3,0), pg(12,1)}, 4'b1111, 1'b0);
      // R3 slot 0 empty, rest in order
      run_case({pg(6,3), pg(6,2), pg(6,1), pg(6,0)}, 4'b1110, 1'b1);
      // R3 in-order prefix followed by a valid tail slot
      run_case({pg(7,3), pg(40,2), pg(7,1), pg(7,0)}, 4'b1011, 1'b1);
      // R4 empty log block
      run_case({pg(0,0), pg(0,1), pg(0,2), pg(0,3)}, 4'b0000, 1'b0);

      for (int t = 0; t < 30; t++) begin
         logic [PG*LW-1:0] l;
         logic [PG-1:0] v;
         int mode, c;
         mode = int'($urandom % 3);
         c = int'($urandom % 1000);
         l = {$urandom, $urandom};
         if (mode == 0) begin
            for (int i = 0; i < PG; i++) l[i*LW +: LW] = pg(c, i);
            v = 4'b1111;
         end else if (mode == 1) begin
            int k;
            k = 1 + int'($urandom % 3);
            v = '0;
            for (int i = 0; i < k; i++) begin l[i*LW +: LW] = pg(c, i); v[i] = 1'b1; end
         end else begin
            for (int i = 0; i < PG; i++) begin
               l[i*LW +: LW] = pg(c + int'($urandom % 3), int'($urandom % 4));
               v[i] = ($urandom % 4) != 0;
            end
         end
         run_case(l, v, 1'b1);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule